// File: doc/BRIEF.md
# Power-Management Event Unit with Interrupt Request

This block collects four power-management event pulses (periodic timer overflow, shared-lock release, power switch press and real-time-clock alarm) into a sticky status register. An enable register selects which of those events may raise a level-sensitive system-control interrupt line. A third 16-bit register holds control bits that software owns in full. Host software reaches the three registers through a 64-byte window in a 16-bit I/O address space. The window base and a window-enable bit live in byte-wide configuration space, so the window can be moved and switched on or off at run time.

Status bits are sticky. An event pulse sets a bit, and host software clears it by writing a one to its position. The interrupt line and a timer-arm output are decoded directly from the registered state. The timer-arm output tells the external timer counter whether an overflow should be reported.

Top module: `pm_event_unit`

## Requirements
- R1: After reset the status, enable and control registers are zero, the window is closed, and both `sci` and `tmr_arm` are low.
- R2: The window base is the 32-bit configuration word at configuration bytes 0x40 (least significant) to 0x43. Its bits 5:0 and 31:16 are ignored. An I/O access hits the window when bit 0 of configuration byte 0x80 is set and `io_addr[15:6]` equals base bits 15:6.
- R3: While the window is closed, or for an address outside it, reads return zero and writes change no register.
- R4: An event pulse sets its status bit on the next clock edge. The bit positions are timer 0, lock 5, power switch 8 and clock alarm 10. Other status bits always read zero.
- R5: A write to window offset 0x00 clears each status bit whose data bit is one. Data bits that are zero leave status unchanged. An event in the same cycle as its clear leaves the bit set.
- R6: Window offset 0x02 is the enable register. Only bits 0, 5, 8 and 10 are writable, so writing 0xFFFF reads back 0x0521.
- R7: Window offset 0x04 is a fully writable 16-bit control register.
- R8: `sci` is high exactly while some bit among 0, 5, 8 and 10 is set in both status and enable. It follows a register change in the same cycle that the change becomes visible.
- R9: `tmr_arm` is high exactly while enable bit 0 is set and status bit 0 is clear.
- R10: Odd offsets and offsets other than 0x00, 0x02 and 0x04 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host 16-bit write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Host read data, combinational, zero on miss |
| ev_tmr | input | 1 | Timer overflow event pulse |
| ev_lock | input | 1 | Shared-lock release event pulse |
| ev_pwr | input | 1 | Power switch event pulse |
| ev_rtc | input | 1 | Clock alarm event pulse |
| sci | output | 1 | Level interrupt request |
| tmr_arm | output | 1 | Timer overflow reporting armed |

## Verification
Configuration writes, host writes and event pulses each take effect at the first rising edge after they are driven. `sci`, `tmr_arm` and read data then follow from the registers with no further delay, so every such result is due one edge after its stimulus. Read data is combinational on `io_rd`, so a read is due in the same cycle it is driven. The bench drives at falling edges and samples one nanosecond after a falling edge. A write's effect is therefore checked after exactly one rising edge, and a read is checked before the next edge can change anything.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_EVT   = 4;
    localparam int WIN_BITS  = 6;

    // event order: timer, lock, power switch, clock alarm
    localparam int EVT_POS [NUM_EVT] = '{0, 5, 8, 10};

    localparam logic [REG_W-1:0] EVT_MASK = 16'h0521;
    localparam int               TMR_BIT  = 0;

    localparam logic [WIN_BITS-1:0] OFF_STS = 6'h00;
    localparam logic [WIN_BITS-1:0] OFF_EN  = 6'h02;
    localparam logic [WIN_BITS-1:0] OFF_CTL = 6'h04;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
    } pm1_state_t;

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs #(
    parameter int          CFG_AW    = 8,
    parameter int          BASE_W    = 32,
    parameter logic [7:0]  BASE_ADDR = 8'h40,
    parameter logic [7:0]  WEN_ADDR  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [BASE_W-1:0] base_q,
    output logic              win_en_q
);
    localparam int NBYTES = BASE_W / 8;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              wen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (cfg_addr == CFG_AW'(BASE_ADDR) + CFG_AW'(i))
                    cfg_d.base[i*8 +: 8] = cfg_wdata;
            end
            if (cfg_addr == CFG_AW'(WEN_ADDR))
                cfg_d.wen = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base_q   = cfg_q.base;
    assign win_en_q = cfg_q.wen;
endmodule

// File: rtl/pm_window_decode.sv
module pm_window_decode #(
    parameter int IO_AW    = 16,
    parameter int BASE_W   = 32,
    parameter int WIN_BITS = 6
) (
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [BASE_W-1:0]   base,
    input  logic                win_en,
    output logic                hit,
    output logic [WIN_BITS-1:0] offset
);
    assign hit    = win_en && (io_addr[IO_AW-1:WIN_BITS] == base[IO_AW-1:WIN_BITS]);
    assign offset = io_addr[WIN_BITS-1:0];
endmodule

// File: rtl/pm1_regs.sv
module pm1_regs
    import pm_event_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [WIN_BITS-1:0] offset,
    input  logic                io_wr,
    input  logic [REG_W-1:0]    io_wdata,
    input  logic [NUM_EVT-1:0]  evt,
    output pm1_state_t          st_q
);
    pm1_state_t st_d, st_r;
    logic [REG_W-1:0] set_bits;
    logic [REG_W-1:0] clr_bits;

    always_comb begin
        set_bits = '0;
        for (int i = 0; i < NUM_EVT; i++)
            if (evt[i]) set_bits[EVT_POS[i]] = 1'b1;

        clr_bits = (io_wr && hit && offset == OFF_STS) ? io_wdata : '0;

        st_d     = st_r;
        st_d.sts = ((st_r.sts & ~clr_bits) | set_bits) & EVT_MASK;
        if (io_wr && hit && offset == OFF_EN)  st_d.en  = io_wdata & EVT_MASK;
        if (io_wr && hit && offset == OFF_CTL) st_d.ctl = io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= '0;
        else        st_r <= st_d;
    end

    assign st_q = st_r;
endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
    import pm_event_pkg::*;
#(
    parameter int IO_AW  = 16,
    parameter int CFG_AW = 8,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    input  logic              ev_tmr,
    input  logic              ev_lock,
    input  logic              ev_pwr,
    input  logic              ev_rtc,
    output logic              sci,
    output logic              tmr_arm
);
    logic [BASE_W-1:0]   base_q;
    logic                win_en_q;
    logic                hit;
    logic [WIN_BITS-1:0] offset;
    pm1_state_t          st_q;
    logic [REG_W-1:0]    rd_mux;

    pm_cfg_regs #(.CFG_AW(CFG_AW), .BASE_W(BASE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .win_en_q(win_en_q)
    );

    pm_window_decode #(.IO_AW(IO_AW), .BASE_W(BASE_W), .WIN_BITS(WIN_BITS)) u_dec (
        .io_addr(io_addr), .base(base_q), .win_en(win_en_q),
        .hit(hit), .offset(offset)
    );

    pm1_regs u_regs (
        .clk(clk), .rst_n(rst_n), .hit(hit), .offset(offset),
        .io_wr(io_wr), .io_wdata(io_wdata),
        .evt({ev_rtc, ev_pwr, ev_lock, ev_tmr}), .st_q(st_q)
    );

    always_comb begin
        case (offset)
            OFF_STS: rd_mux = st_q.sts;
            OFF_EN:  rd_mux = st_q.en;
            OFF_CTL: rd_mux = st_q.ctl;
            default: rd_mux = '0;
        endcase
    end

    assign io_rdata = (io_rd && hit) ? rd_mux : '0;
    assign sci      = |(st_q.sts & st_q.en & EVT_MASK);
    assign tmr_arm  = st_q.en[TMR_BIT] && !st_q.sts[TMR_BIT];
endmodule

// File: rtl/pm_event_unit_chk.sv
module pm_event_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hit,
    input logic [5:0]  offset,
    input logic        io_wr,
    input logic [15:0] io_wdata,
    input logic        ev_tmr,
    input logic        ev_lock,
    input logic        ev_pwr,
    input logic        ev_rtc,
    input logic [15:0] sts,
    input logic [15:0] en,
    input logic [15:0] ctl,
    input logic        sci,
    input logic        tmr_arm
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sts == 16'h0 && en == 16'h0 && ctl == 16'h0));

    p_miss_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hit) |=> ($stable(en) && $stable(ctl)));

    p_rtc_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rtc |=> sts[10]);

    p_lock_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lock |=> sts[5]);

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit && offset == 6'h00 && io_wdata[8] && !ev_pwr) |=> !sts[8]);

    p_sts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && !ev_tmr && !ev_lock && !ev_pwr && !ev_rtc) |=> $stable(sts));

    p_pwr_raises_sci_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pwr && en[8] && !(io_wr && hit)) |=> sci);

    p_tmr_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmr |=> !tmr_arm);
endmodule

bind pm_event_unit pm_event_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hit(hit), .offset(offset),
    .io_wr(io_wr), .io_wdata(io_wdata),
    .ev_tmr(ev_tmr), .ev_lock(ev_lock), .ev_pwr(ev_pwr), .ev_rtc(ev_rtc),
    .sts(st_q.sts), .en(st_q.en), .ctl(st_q.ctl),
    .sci(sci), .tmr_arm(tmr_arm)
);

// File: tb/pm_event_unit_bench.sv
`timescale 1ns/1ps
module pm_event_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        ev_tmr = 1'b0, ev_lock = 1'b0, ev_pwr = 1'b0, ev_rtc = 1'b0;
    logic        sci, tmr_arm;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pm_event_unit u_pm_event_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ev_tmr(ev_tmr),
        .ev_lock(ev_lock), .ev_pwr(ev_pwr), .ev_rtc(ev_rtc),
        .sci(sci), .tmr_arm(tmr_arm)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_tmr = 1'b1;
            1: ev_lock = 1'b1;
            2: ev_pwr = 1'b1;
            default: ev_rtc = 1'b1;
        endcase
        @(negedge clk);
        ev_tmr = 1'b0; ev_lock = 1'b0; ev_pwr = 1'b0; ev_rtc = 1'b0;
    endtask

    task automatic open_window(input logic [7:0] lo, input logic [7:0] hi);
        cfg_write(8'h40, lo);
        cfg_write(8'h41, hi);
        cfg_write(8'h80, 8'h01);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        #1;
        check("R1", "sci after reset", {15'h0, sci}, 16'h0);
        check("R1", "tmr_arm after reset", {15'h0, tmr_arm}, 16'h0);
        io_read(16'h0004, d);
        check("R3", "read while closed", d, 16'h0);
        io_write(16'h0002, 16'hFFFF);
        cfg_write(8'h80, 8'h01);
        io_read(16'h0002, d);
        check("R3", "enable after closed write", d, 16'h0);
        io_read(16'h0000, d);
        check("R1", "status after reset", d, 16'h0);
        io_read(16'h0004, d);
        check("R1", "control after reset", d, 16'h0);
    endtask

    task automatic t_window;
        logic [15:0] d;
        open_window(8'h3F, 8'h40);
        io_write(16'h4004, 16'hBEEF);
        io_read(16'h4004, d);
        check("R7", "control readback", d, 16'hBEEF);
        io_read(16'h4044, d);
        check("R2", "read above window", d, 16'h0);
        io_write(16'h0004, 16'h1234);
        io_read(16'h4004, d);
        check("R3", "write outside window", d, 16'hBEEF);
        cfg_write(8'h80, 8'h02);
        io_read(16'h4004, d);
        check("R2", "enable byte bit0 clear", d, 16'h0);
        cfg_write(8'h80, 8'h01);
        cfg_write(8'h40, 8'h40);
        cfg_write(8'h41, 8'h80);
        io_read(16'h8044, d);
        check("R2", "relocated window", d, 16'hBEEF);
        io_read(16'h4004, d);
        check("R2", "old window gone", d, 16'h0);
        cfg_write(8'h42, 8'hFF);
        io_read(16'h8044, d);
        check("R2", "upper base bits ignored", d, 16'hBEEF);
        open_window(8'h00, 8'h40);
    endtask

    task automatic t_enable;
        logic [15:0] d;
        io_write(16'h4002, 16'hFFFF);
        io_read(16'h4002, d);
        check("R6", "enable implemented bits", d, 16'h0521);
        io_write(16'h4002, 16'h0000);
        io_read(16'h4002, d);
        check("R6", "enable cleared", d, 16'h0);
    endtask

    task automatic t_events;
        logic [15:0] d;
        pulse(2);
        #1 check("R8", "sci with enable off", {15'h0, sci}, 16'h0);
        io_read(16'h4000, d);
        check("R4", "power switch bit 8", d, 16'h0100);
        io_write(16'h4002, 16'h0100);
        #1 check("R8", "sci on enable set", {15'h0, sci}, 16'h1);
        io_write(16'h4002, 16'h0521);
        pulse(0); pulse(1); pulse(3);
        io_read(16'h4000, d);
        check("R4", "all four status bits", d, 16'h0521);
        io_write(16'h4000, 16'h0000);
        io_read(16'h4000, d);
        check("R5", "zero write keeps status", d, 16'h0521);
        io_write(16'h4000, 16'h0021);
        io_read(16'h4000, d);
        check("R5", "partial clear", d, 16'h0500);
        check("R8", "sci still high", {15'h0, sci}, 16'h1);
        io_write(16'h4000, 16'h0500);
        #1 check("R8", "sci low after last clear", {15'h0, sci}, 16'h0);
        @(negedge clk);
        ev_rtc = 1'b1; io_wr = 1'b1; io_addr = 16'h4000; io_wdata = 16'h0400;
        @(negedge clk);
        ev_rtc = 1'b0; io_wr = 1'b0;
        io_read(16'h4000, d);
        check("R5", "event beats clear", d, 16'h0400);
        io_write(16'h4002, 16'h0000);
        #1 check("R8", "sci drops with enable", {15'h0, sci}, 16'h0);
        io_write(16'h4000, 16'hFFFF);
    endtask

    task automatic t_arm;
        #1 check("R9", "arm with enable off", {15'h0, tmr_arm}, 16'h0);
        io_write(16'h4002, 16'h0001);
        #1 check("R9", "arm on enable", {15'h0, tmr_arm}, 16'h1);
        pulse(0);
        #1 check("R9", "disarm on status", {15'h0, tmr_arm}, 16'h0);
        check("R8", "timer raises sci", {15'h0, sci}, 16'h1);
        io_write(16'h4000, 16'h0001);
        #1 check("R9", "rearm on clear", {15'h0, tmr_arm}, 16'h1);
    endtask

    task automatic t_unimpl;
        logic [15:0] d;
        io_write(16'h4006, 16'hFFFF);
        io_read(16'h4006, d);
        check("R10", "offset 6 reads zero", d, 16'h0);
        io_write(16'h4003, 16'hFFFF);
        io_read(16'h4002, d);
        check("R10", "odd write ignored", d, 16'h0001);
        io_read(16'h4005, d);
        check("R10", "odd read zero", d, 16'h0);
        io_read(16'h403E, d);
        check("R10", "top offset zero", d, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired (all requirements): actual hang expected finish");
        n_fail++; n_chk++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_enable();
        t_events();
        t_arm();
        t_unimpl();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule